// File: doc/BRIEF.md
# Line Driver Fault Flag and Output Control

This block collects the health indications of a dual-output serial line driver and turns them into control signals. Five conditions feed it: one input flag that reads 1 while a valid signal is present, and four termination-fault flags, two for each output. Each condition can be inverted and can be masked. The block ORs the unmasked conditions that are in their fault state into one active-low fault flag. That flag is registered, so it never glitches. Several drivers can share one wired fault line.

The same block settles the power state of each output stage. It combines an enable pin, a power-down bit per output, and an optional link that powers both stages down while the input signal is missing. It also picks the output edge rate from a pin and a register bit. While the input signal is absent, it drives either a mute command or an add-offset command, and two force bits can override that action. Everything except the fault flag is combinational.

Top module: `sdo_fault_ctl`

## Requirements
- R1: `fault_n` is registered. It reads 1 while `rst` is high. After each clock edge it shows the fault state computed from the inputs present at that edge.
- R2: For termination flag i (bit i of `term_flag`, bits 0/1 belong to output 0 and bits 2/3 to output 1), the condition is in fault when `term_flag[i]` differs from `term_inv[i]`. With `term_inv[i]`=0 a flag of 1 is a fault; with `term_inv[i]`=1 a flag of 0 is a fault.
- R3: The signal condition is in fault when `sig_present` equals `sig_inv`. With `sig_inv`=0 a missing signal (0) is a fault; with `sig_inv`=1 a present signal (1) is a fault.
- R4: A condition whose mask bit is 1 (`term_mask[i]` or `sig_mask`) never pulls `fault_n` low. `fault_n` is 0 exactly when at least one unmasked condition is in fault.
- R5: With `en_pin` low, both bits of `pd_out` are 1, regardless of `pd_bits` and `loss_link`.
- R6: With `en_pin` high, `loss_link` low, `pd_out[k]` equals `pd_bits[k]` for each output k.
- R7: With `en_pin` high and `loss_link` high, `sig_present`=0 sets both `pd_out` bits to 1. `sig_present`=1 leaves each bit equal to `pd_bits[k]`.
- R8: `slow_rate` is 1 whenever `rate_pin` is 1. With `rate_pin` 0, `slow_rate` equals `rate_bit`.
- R9: While the loss action applies, `mute_sel`=1 drives `mute_cmd`=1 and `mute_sel`=0 drives `offset_cmd`=1. The two commands are never 1 together, and both are 0 when the action does not apply. Without force bits, the action applies exactly when `sig_present`=0.
- R10: `force_off`=1 makes the loss action apply whatever `sig_present` is. `force_on`=1 stops it from applying. When both are 1, `force_on` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_present | input | 1 | 1 while a valid input signal is present |
| term_flag | input | 4 | Termination-fault flags, two per output |
| term_mask | input | 4 | Mask bit for each termination flag |
| term_inv | input | 4 | Polarity bit for each termination flag |
| sig_mask | input | 1 | Mask bit for the signal condition |
| sig_inv | input | 1 | Polarity bit for the signal condition |
| en_pin | input | 1 | Driver enable pin, low powers both outputs down |
| pd_bits | input | 2 | Power-down bit for each output |
| loss_link | input | 1 | Ties signal loss to output power-down |
| rate_pin | input | 1 | Edge-rate pin, high forces slow edges |
| rate_bit | input | 1 | Edge-rate register bit, 1 = slow |
| mute_sel | input | 1 | 1 = mute on loss, 0 = add offset on loss |
| force_off | input | 1 | Loss action always applies |
| force_on | input | 1 | Loss action never applies |
| fault_n | output | 1 | Registered active-low fault flag |
| pd_out | output | 2 | Power-down control per output |
| slow_rate | output | 1 | 1 selects slow edges |
| mute_cmd | output | 1 | Mute command |
| offset_cmd | output | 1 | Add-offset command |

## Verification
`pd_out`, `slow_rate`, `mute_cmd` and `offset_cmd` follow their inputs in the same cycle. The bench applies every input set just after a falling edge and checks these four a nanosecond later, before any rising edge. `fault_n` has one register in its path. For it, the bench holds the same inputs across the next rising edge and compares the flag one nanosecond after that edge against the value predicted from those held inputs. Random input sets are mixed with directed cases for full masking, each polarity, enable low, the loss link, and both force bits set together.

// File: rtl/fault_ctl_pkg.sv
package fault_ctl_pkg;

    parameter int NUM_TERM = 4;
    parameter int NUM_OUT  = 2;
    localparam int NUM_COND = NUM_TERM + 1;

    typedef enum logic [1:0] {
        LOSS_NONE   = 2'b00,
        LOSS_MUTE   = 2'b01,
        LOSS_OFFSET = 2'b10
    } loss_cmd_e;

    typedef struct packed {
        logic en_pin;
        logic loss_link;
        logic sig_present;
    } pwr_ctl_t;

    // Termination flag: fault when the flag differs from its polarity bit.
    function automatic logic term_fault(input logic flag, input logic inv);
        return flag ^ inv;
    endfunction

    // Signal flag is 1 when present: fault when it equals its polarity bit.
    function automatic logic sig_fault(input logic present, input logic inv);
        return ~(present ^ inv);
    endfunction

    // Precedence: force_on, then force_off, then the live signal flag.
    function automatic logic loss_applies(input logic present,
                                          input logic f_off,
                                          input logic f_on);
        if (f_on)  return 1'b0;
        if (f_off) return 1'b1;
        return ~present;
    endfunction

endpackage

// File: rtl/fault_merge.sv
module fault_merge
    import fault_ctl_pkg::*;
#(
    parameter int N_TERM = NUM_TERM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TERM-1:0] term_flag,
    input  logic [N_TERM-1:0] term_mask,
    input  logic [N_TERM-1:0] term_inv,
    input  logic              sig_present,
    input  logic              sig_mask,
    input  logic              sig_inv,
    output logic              fault_n
);
    localparam int N_COND = N_TERM + 1;

    logic [N_COND-1:0] cond_hit;
    logic [N_COND-1:0] cond_mask;
    logic              any_fault;

    for (genvar i = 0; i < N_TERM; i++) begin : g_term
        assign cond_hit[i]  = term_fault(term_flag[i], term_inv[i]);
        assign cond_mask[i] = term_mask[i];
    end
    assign cond_hit[N_COND-1]  = sig_fault(sig_present, sig_inv);
    assign cond_mask[N_COND-1] = sig_mask;

    assign any_fault = |(cond_hit & ~cond_mask);

    always_ff @(posedge clk) begin
        if (rst) fault_n <= 1'b1;
        else     fault_n <= ~any_fault;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> fault_n);

    assert_all_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (&term_mask && sig_mask) |=> fault_n);

    assert_sig_polarity_R3: assert property (@(posedge clk) disable iff (rst)
        (!sig_mask && (sig_present == sig_inv)) |=> !fault_n);

    assert_term_polarity_R2: assert property (@(posedge clk) disable iff (rst)
        (|((term_flag ^ term_inv) & ~term_mask)) |=> !fault_n);

endmodule

// File: rtl/power_resolve.sv
module power_resolve
    import fault_ctl_pkg::*;
#(
    parameter int N_OUT = NUM_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  pwr_ctl_t         ctl,
    input  logic [N_OUT-1:0] pd_bits,
    input  logic             rate_pin,
    input  logic             rate_bit,
    output logic [N_OUT-1:0] pd_out,
    output logic             slow_rate
);
    logic force_down;

    assign force_down = ~ctl.en_pin | (ctl.loss_link & ~ctl.sig_present);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign pd_out[k] = force_down | pd_bits[k];
    end

    assign slow_rate = rate_pin | rate_bit;

    assert_enable_low_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.en_pin |-> (&pd_out));

    assert_link_loss_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.loss_link && !ctl.sig_present) |-> (&pd_out));

    assert_rate_pin_R8: assert property (@(posedge clk) disable iff (rst)
        rate_pin |-> slow_rate);

endmodule

// File: rtl/loss_action.sv
module loss_action
    import fault_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_present,
    input  logic mute_sel,
    input  logic force_off,
    input  logic force_on,
    output logic mute_cmd,
    output logic offset_cmd
);
    loss_cmd_e cmd;

    always_comb begin
        cmd = LOSS_NONE;
        if (loss_applies(sig_present, force_off, force_on))
            cmd = mute_sel ? LOSS_MUTE : LOSS_OFFSET;
    end

    assign mute_cmd   = (cmd == LOSS_MUTE);
    assign offset_cmd = (cmd == LOSS_OFFSET);

    assert_cmd_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({mute_cmd, offset_cmd}) <= 1);

    assert_force_on_wins_R10: assert property (@(posedge clk) disable iff (rst)
        force_on |-> (!mute_cmd && !offset_cmd));

    assert_present_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (sig_present && !force_off) |-> (!mute_cmd && !offset_cmd));

endmodule

// File: rtl/sdo_fault_ctl.sv
module sdo_fault_ctl
    import fault_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sig_present,
    input  logic [NUM_TERM-1:0] term_flag,
    input  logic [NUM_TERM-1:0] term_mask,
    input  logic [NUM_TERM-1:0] term_inv,
    input  logic                sig_mask,
    input  logic                sig_inv,
    input  logic                en_pin,
    input  logic [NUM_OUT-1:0]  pd_bits,
    input  logic                loss_link,
    input  logic                rate_pin,
    input  logic                rate_bit,
    input  logic                mute_sel,
    input  logic                force_off,
    input  logic                force_on,
    output logic                fault_n,
    output logic [NUM_OUT-1:0]  pd_out,
    output logic                slow_rate,
    output logic                mute_cmd,
    output logic                offset_cmd
);
    pwr_ctl_t pctl;

    assign pctl.en_pin      = en_pin;
    assign pctl.loss_link   = loss_link;
    assign pctl.sig_present = sig_present;

    fault_merge #(.N_TERM(NUM_TERM)) u_merge (
        .clk         (clk),
        .rst         (rst),
        .term_flag   (term_flag),
        .term_mask   (term_mask),
        .term_inv    (term_inv),
        .sig_present (sig_present),
        .sig_mask    (sig_mask),
        .sig_inv     (sig_inv),
        .fault_n     (fault_n)
    );

    power_resolve #(.N_OUT(NUM_OUT)) u_power (
        .clk       (clk),
        .rst       (rst),
        .ctl       (pctl),
        .pd_bits   (pd_bits),
        .rate_pin  (rate_pin),
        .rate_bit  (rate_bit),
        .pd_out    (pd_out),
        .slow_rate (slow_rate)
    );

    loss_action u_loss (
        .clk         (clk),
        .rst         (rst),
        .sig_present (sig_present),
        .mute_sel    (mute_sel),
        .force_off   (force_off),
        .force_on    (force_on),
        .mute_cmd    (mute_cmd),
        .offset_cmd  (offset_cmd)
    );

endmodule

// File: tb/sim_sdo_fault_ctl.sv
`timescale 1ns/1ps
module sim_sdo_fault_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_present = 1'b1;
    logic [3:0] term_flag = '0, term_mask = '0, term_inv = '0;
    logic       sig_mask = 1'b0, sig_inv = 1'b0, en_pin = 1'b1;
    logic [1:0] pd_bits = '0;
    logic       loss_link = 1'b0, rate_pin = 1'b0, rate_bit = 1'b0;
    logic       mute_sel = 1'b0, force_off = 1'b0, force_on = 1'b0;
    logic       fault_n, slow_rate, mute_cmd, offset_cmd;
    logic [1:0] pd_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdo_fault_ctl u0 (.*);

    function automatic logic exp_fault_n();
        logic f = 1'b0;
        for (int i = 0; i < 4; i++)
            if (!term_mask[i] && (term_inv[i] ? !term_flag[i] : term_flag[i])) f = 1'b1;
        if (!sig_mask && (sig_inv ? sig_present : !sig_present)) f = 1'b1;
        return !f;
    endfunction

    function automatic logic [1:0] exp_pd();
        if (!en_pin) return 2'b11;
        if (loss_link && !sig_present) return 2'b11;
        return pd_bits;
    endfunction

    function automatic logic loss_on();
        if (force_on)  return 1'b0;
        if (force_off) return 1'b1;
        return !sig_present;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Inputs applied after a falling edge; combinational results checked 1 ns later,
    // fault_n checked 1 ns after the next rising edge.
    task automatic step_and_check();
        logic efn;
        #1;
        check("R5/R6/R7 pd_out", pd_out, exp_pd());
        check("R8 slow_rate", {1'b0, slow_rate}, {1'b0, rate_pin | rate_bit});
        check("R9/R10 mute_cmd", {1'b0, mute_cmd}, {1'b0, loss_on() & mute_sel});
        check("R9/R10 offset_cmd", {1'b0, offset_cmd}, {1'b0, loss_on() & !mute_sel});
        efn = exp_fault_n();
        @(posedge clk); #1;
        check("R1/R2/R3/R4 fault_n", {1'b0, fault_n}, {1'b0, efn});
        @(negedge clk);
    endtask

    task automatic clear_all();
        sig_present = 1'b1; term_flag = '0; term_mask = '0; term_inv = '0;
        sig_mask = 0; sig_inv = 0; en_pin = 1; pd_bits = '0; loss_link = 0;
        rate_pin = 0; rate_bit = 0; mute_sel = 0; force_off = 0; force_on = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, with a fault pending on the inputs
        term_flag = 4'b0001;
        repeat (3) @(posedge clk);
        #1 check("R1 reset fault_n", {1'b0, fault_n}, 2'b01);
        @(negedge clk); rst = 1'b0;
        clear_all();
        step_and_check();
        // R2: each termination flag under both polarities
        for (int i = 0; i < 4; i++) begin
            clear_all(); term_flag[i] = 1'b1; step_and_check();
            clear_all(); term_inv[i] = 1'b1; step_and_check();
        end
        // R3: signal polarity
        clear_all(); sig_present = 0; step_and_check();
        clear_all(); sig_inv = 1; step_and_check();
        // R4: all conditions faulted but every one masked
        clear_all(); term_flag = 4'hF; sig_present = 0; term_mask = 4'hF; sig_mask = 1;
        step_and_check();
        // R5: enable low overrides pd bits
        clear_all(); en_pin = 0; step_and_check();
        // R6: per-output pd bits
        clear_all(); pd_bits = 2'b10; step_and_check();
        // R7: link with signal lost and present
        clear_all(); loss_link = 1; sig_present = 0; step_and_check();
        clear_all(); loss_link = 1; pd_bits = 2'b01; step_and_check();
        // R8: pin forces slow
        clear_all(); rate_pin = 1; step_and_check();
        // R9: mute vs offset on loss
        clear_all(); sig_present = 0; mute_sel = 1; step_and_check();
        // R10: force bits, including both set
        clear_all(); force_off = 1; mute_sel = 1; step_and_check();
        clear_all(); force_on = 1; sig_present = 0; step_and_check();
        clear_all(); force_on = 1; force_off = 1; sig_present = 0; step_and_check();
        // Random mix over all requirements R1..R10
        for (int n = 0; n < 500; n++) begin
            logic [31:0] r = $urandom();
            logic [31:0] s = $urandom();
            sig_present = r[0]; term_flag = r[4:1]; term_mask = r[8:5] & s[3:0];
            term_inv = r[12:9]; sig_mask = r[13] & s[4]; sig_inv = r[14];
            en_pin = r[15] | r[16]; pd_bits = r[18:17]; loss_link = r[19];
            rate_pin = r[20]; rate_bit = r[21]; mute_sel = r[22];
            force_off = r[23] & r[24]; force_on = r[25] & r[26];
            step_and_check();
        end
        summary();
    end
endmodule